// File: doc/BRIEF.md
# DDR2 Command Decoder and Bank Tracker

This block sits beside a DDR2 controller's command pins and watches them. On every rising clock it turns the chip select, row strobe, column strobe, write enable, clock enable, bank address and A10 inputs into one command. It then follows how that command moves four banks and the device as a whole through their states. Each bank is tracked as idle, activating, active, reading, writing, auto-precharging or precharging. The device is tracked as initializing, idle, refreshing, in self refresh, or in one of two power-down modes.

Any command that is not allowed in the current state raises a one-cycle flag and changes nothing. Short programmable cycle counters stand in for the row-to-column delay, the precharge time, the refresh time, the burst duration and the initialization wait, and they return banks and the device to their resting states. A monitor or a protocol checker can use the block to track the DRAM state without modelling any analog timing.

Top module: `ddr2_cmd_tracker`

## Requirements
- R1: On each rising edge the command is decoded from {ras_ni,cas_ni,we_ni} while cs_ni is low, with the codes 0 mode load, 1 refresh, 2 precharge, 3 activate, 4 write, 5 read, 6 reserved and 7 no-op. When cs_ni is high the command is a no-op. `cmd_o` shows the decoded code one cycle later.
- R2: Reset puts the device state at 0 (init), every bank state at 0 (idle), and clears `illegal_o` and `mode_load_o`. The device goes to state 1 (idle) after T_INIT rising edges.
- R3: During init, any command other than a no-op is illegal.
- R4: An activate to an idle bank puts that bank in state 1 (activating) for T_RCD cycles and then in state 2 (active). An activate to a bank that is not idle is illegal.
- R5: A read or write with A10 low is legal only to a bank in state 2, 3 or 4. It moves the bank to state 3 (reading) or 4 (writing) for T_BURST cycles, and the bank then returns to state 2. A read or write to any other bank state is illegal.
- R6: A read or write with A10 high puts the bank in state 5 (auto-precharge) for T_BURST cycles, then in state 6 (precharging) for T_RP cycles, and then in state 0.
- R7: A precharge with A10 low acts on the bank selected by ba_i. A precharge with A10 high acts on all banks, and is legal only if every bank is in state 0, 2 or 6. Each active bank it reaches goes to state 6 for T_RP cycles. A bank in state 0 or 6 is left as it is. A precharge that reaches a bank in state 1, 3, 4 or 5 is illegal.
- R8: Mode load and refresh are legal only when all banks are idle. A mode load pulses `mode_load_o` and sets `mode_sel_o` to ba_i. A refresh holds the device in state 2 for T_RFC cycles.
- R9: With cke_i low in device state 1, a refresh with all banks idle enters state 3 (self refresh). A no-op with all banks idle enters state 4 (precharge power-down). A no-op with at least one bank active and no bank in state 1, 3, 4, 5 or 6 enters state 5 (active power-down). Every other case is illegal. In states 3, 4 and 5, commands are ignored, and cke_i high returns the device to state 1.
- R10: The reserved code is always illegal. `illegal_o` is high for exactly the cycle after each illegal command, and that command changes neither bank nor device state.
- R11: While refreshing (device state 2), any command other than a no-op is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Registered clock enable |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | BA_W | Bank address, or mode register select |
| a10_i | input | 1 | Auto-precharge / all-bank select |
| cmd_o | output | 3 | Decoded command code of the last edge |
| illegal_o | output | 1 | One-cycle flag for an illegal command |
| dev_state_o | output | 3 | Device state code |
| bank_state_o | output | NUM_BANKS*3 | Bank b state in bits [3b+2:3b] |
| mode_load_o | output | 1 | Pulse on a legal mode load |
| mode_sel_o | output | BA_W | Mode register chosen by the last legal mode load |

## Verification
The assertions assume only that every timing parameter is at least one. They make no assumption about the command stream: every legality rule is enforced inside the block, so a hostile sequence can only raise the illegal flag and cannot break the state invariants. The random stimulus therefore draws from the full command space, including reserved codes, deselects and clock-enable drops at any moment. Its weights favour no-ops and a high clock enable so that the timed states run to completion and the power-down and self-refresh paths are reached often.

// File: rtl/ddr2_trk_pkg.sv
package ddr2_trk_pkg;

  typedef enum logic [2:0] {
    CMD_MRS = 3'd0,
    CMD_REF = 3'd1,
    CMD_PRE = 3'd2,
    CMD_ACT = 3'd3,
    CMD_WR  = 3'd4,
    CMD_RD  = 3'd5,
    CMD_RSV = 3'd6,
    CMD_NOP = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    B_IDLE    = 3'd0,
    B_ACTVING = 3'd1,
    B_ACTIVE  = 3'd2,
    B_READING = 3'd3,
    B_WRITING = 3'd4,
    B_AUTOPRE = 3'd5,
    B_PRECHG  = 3'd6
  } bank_st_e;

  typedef enum logic [2:0] {
    D_INIT    = 3'd0,
    D_IDLE    = 3'd1,
    D_REFRESH = 3'd2,
    D_SELFREF = 3'd3,
    D_PD_PRE  = 3'd4,
    D_PD_ACT  = 3'd5
  } dev_st_e;

  function automatic int tmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/trk_cmd_decode.sv
module trk_cmd_decode
  import ddr2_trk_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);

  always_comb begin
    if (cs_ni) cmd_o = CMD_NOP;
    else       cmd_o = cmd_e'({ras_ni, cas_ni, we_ni});
  end

endmodule

// File: rtl/trk_bank_fsm.sv
module trk_bank_fsm
  import ddr2_trk_pkg::*;
#(
  parameter int T_RCD   = 3,
  parameter int T_RP    = 3,
  parameter int T_BURST = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     act_i,
  input  logic     rd_i,
  input  logic     wr_i,
  input  logic     ap_i,
  input  logic     pre_i,
  output bank_st_e state_o
);

  localparam int MAXT  = tmax(tmax(T_RCD, T_RP), T_BURST);
  localparam int CNT_W = $clog2(MAXT + 1);

  bank_st_e   st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= B_IDLE;
      cnt_q <= '0;
    end else if (act_i) begin
      st_q  <= B_ACTVING;
      cnt_q <= CNT_W'(T_RCD - 1);
    end else if (rd_i || wr_i) begin
      st_q  <= ap_i ? B_AUTOPRE : (rd_i ? B_READING : B_WRITING);
      cnt_q <= CNT_W'(T_BURST - 1);
    end else if (pre_i) begin
      st_q  <= B_PRECHG;
      cnt_q <= CNT_W'(T_RP - 1);
    end else begin
      unique case (st_q)
        B_ACTVING, B_READING, B_WRITING: begin
          if (cnt_q == '0) st_q <= B_ACTIVE;
          else             cnt_q <= cnt_q - CNT_W'(1);
        end
        B_AUTOPRE: begin
          if (cnt_q == '0) begin
            st_q  <= B_PRECHG;
            cnt_q <= CNT_W'(T_RP - 1);
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        B_PRECHG: begin
          if (cnt_q == '0) st_q <= B_IDLE;
          else             cnt_q <= cnt_q - CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign state_o = st_q;

  // R4: a bank only opens from activation or a finished plain burst
  a_r4_open_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q == B_ACTIVE) |->
      ($past(st_q) inside {B_ACTVING, B_READING, B_WRITING}));

  // R6: auto-precharge always hands over to precharging
  a_r6_autopre_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(st_q == B_AUTOPRE) |-> (st_q == B_PRECHG));

  // R7: precharging ends only in idle
  a_r7_prechg_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(st_q == B_PRECHG) |-> (st_q == B_IDLE));

endmodule

// File: rtl/trk_dev_ctrl.sv
module trk_dev_ctrl
  import ddr2_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_INIT    = 8,
  parameter int T_RFC     = 10,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cke_i,
  input  cmd_e                      cmd_i,
  input  logic [BA_W-1:0]           ba_i,
  input  logic                      a10_i,
  input  logic [NUM_BANKS-1:0][2:0] bst_i,
  output logic [NUM_BANKS-1:0]      act_o,
  output logic [NUM_BANKS-1:0]      rd_o,
  output logic [NUM_BANKS-1:0]      wr_o,
  output logic [NUM_BANKS-1:0]      pre_o,
  output logic                      ap_o,
  output dev_st_e                   dev_o,
  output logic                      illegal_o,
  output logic                      mode_load_o,
  output logic [BA_W-1:0]           mode_sel_o,
  output cmd_e                      cmd_o
);

  localparam int CNT_W = $clog2(tmax(T_INIT, T_RFC) + 1);

  dev_st_e          dev_q, dev_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ill_d, mload_d;
  logic             all_idle, none_trans, any_active, pall_ok;
  logic [2:0]       tgt;

  always_comb begin
    all_idle   = 1'b1;
    none_trans = 1'b1;
    any_active = 1'b0;
    pall_ok    = 1'b1;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bst_i[b] != B_IDLE) all_idle = 1'b0;
      if (bst_i[b] == B_ACTIVE) any_active = 1'b1;
      if (!(bst_i[b] inside {B_IDLE, B_ACTIVE})) none_trans = 1'b0;
      if (!(bst_i[b] inside {B_IDLE, B_ACTIVE, B_PRECHG})) pall_ok = 1'b0;
    end
  end

  assign tgt  = bst_i[ba_i];
  assign ap_o = a10_i;

  always_comb begin
    dev_d   = dev_q;
    cnt_d   = cnt_q;
    ill_d   = 1'b0;
    mload_d = 1'b0;
    act_o   = '0;
    rd_o    = '0;
    wr_o    = '0;
    pre_o   = '0;
    unique case (dev_q)
      D_INIT, D_REFRESH: begin
        ill_d = (cmd_i != CMD_NOP);
        if (cnt_q == '0) dev_d = D_IDLE;
        else             cnt_d = cnt_q - CNT_W'(1);
      end
      D_SELFREF, D_PD_PRE, D_PD_ACT: begin
        if (cke_i) dev_d = D_IDLE;
      end
      D_IDLE: begin
        if (!cke_i) begin
          if (cmd_i == CMD_REF) begin
            if (all_idle) dev_d = D_SELFREF;
            else          ill_d = 1'b1;
          end else if (cmd_i != CMD_NOP) begin
            ill_d = 1'b1;
          end else if (all_idle) begin
            dev_d = D_PD_PRE;
          end else if (none_trans && any_active) begin
            dev_d = D_PD_ACT;
          end else begin
            ill_d = 1'b1;
          end
        end else begin
          unique case (cmd_i)
            CMD_MRS: begin
              if (all_idle) mload_d = 1'b1;
              else          ill_d   = 1'b1;
            end
            CMD_REF: begin
              if (all_idle) begin
                dev_d = D_REFRESH;
                cnt_d = CNT_W'(T_RFC - 1);
              end else begin
                ill_d = 1'b1;
              end
            end
            CMD_PRE: begin
              if (a10_i) begin
                if (pall_ok) begin
                  for (int b = 0; b < NUM_BANKS; b++)
                    pre_o[b] = (bst_i[b] == B_ACTIVE);
                end else begin
                  ill_d = 1'b1;
                end
              end else if (tgt == B_ACTIVE) begin
                pre_o[ba_i] = 1'b1;
              end else if (!(tgt inside {B_IDLE, B_PRECHG})) begin
                ill_d = 1'b1;
              end
            end
            CMD_ACT: begin
              if (tgt == B_IDLE) act_o[ba_i] = 1'b1;
              else               ill_d = 1'b1;
            end
            CMD_RD, CMD_WR: begin
              if (tgt inside {B_ACTIVE, B_READING, B_WRITING}) begin
                if (cmd_i == CMD_RD) rd_o[ba_i] = 1'b1;
                else                 wr_o[ba_i] = 1'b1;
              end else begin
                ill_d = 1'b1;
              end
            end
            CMD_RSV: ill_d = 1'b1;
            default: ;
          endcase
        end
      end
      default: dev_d = D_INIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dev_q       <= D_INIT;
      cnt_q       <= CNT_W'(T_INIT - 1);
      illegal_o   <= 1'b0;
      mode_load_o <= 1'b0;
      mode_sel_o  <= '0;
      cmd_o       <= CMD_NOP;
    end else begin
      dev_q       <= dev_d;
      cnt_q       <= cnt_d;
      illegal_o   <= ill_d;
      mode_load_o <= mload_d;
      if (mload_d) mode_sel_o <= ba_i;
      cmd_o       <= cmd_i;
    end
  end

  assign dev_o = dev_q;

  // R9: self refresh and precharge power-down only with every bank idle
  a_r9_selfref_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_q inside {D_SELFREF, D_PD_PRE}) |-> all_idle);

  // R9: active power-down holds open rows and no timed bank activity
  a_r9_pdact_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_q == D_PD_ACT) |-> (any_active && none_trans));

  // R8: refresh runs with all banks precharged
  a_r8_refresh_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_q == D_REFRESH) |-> all_idle);

  // R8: a mode load is only reported with all banks idle
  a_r8_mload_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_load_o |-> all_idle);

  // R10: at most one bank receives a command per edge
  a_r10_single_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act_o | rd_o | wr_o) && (((act_o | rd_o | wr_o) & pre_o) == '0));

endmodule

// File: rtl/ddr2_cmd_tracker.sv
module ddr2_cmd_tracker
  import ddr2_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_INIT    = 8,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 10,
  parameter int T_BURST   = 2,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cke_i,
  input  logic                   cs_ni,
  input  logic                   ras_ni,
  input  logic                   cas_ni,
  input  logic                   we_ni,
  input  logic [BA_W-1:0]        ba_i,
  input  logic                   a10_i,
  output logic [2:0]             cmd_o,
  output logic                   illegal_o,
  output logic [2:0]             dev_state_o,
  output logic [NUM_BANKS*3-1:0] bank_state_o,
  output logic                   mode_load_o,
  output logic [BA_W-1:0]        mode_sel_o
);

  cmd_e                      cmd_now, cmd_q;
  dev_st_e                   dev;
  logic [NUM_BANKS-1:0][2:0] bst;
  logic [NUM_BANKS-1:0]      act, rd, wr, pre;
  logic                      ap;

  trk_cmd_decode u_dec (
    .cs_ni  (cs_ni),
    .ras_ni (ras_ni),
    .cas_ni (cas_ni),
    .we_ni  (we_ni),
    .cmd_o  (cmd_now)
  );

  trk_dev_ctrl #(
    .NUM_BANKS (NUM_BANKS),
    .T_INIT    (T_INIT),
    .T_RFC     (T_RFC)
  ) u_dev (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cke_i       (cke_i),
    .cmd_i       (cmd_now),
    .ba_i        (ba_i),
    .a10_i       (a10_i),
    .bst_i       (bst),
    .act_o       (act),
    .rd_o        (rd),
    .wr_o        (wr),
    .pre_o       (pre),
    .ap_o        (ap),
    .dev_o       (dev),
    .illegal_o   (illegal_o),
    .mode_load_o (mode_load_o),
    .mode_sel_o  (mode_sel_o),
    .cmd_o       (cmd_q)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_st_e st;
    trk_bank_fsm #(
      .T_RCD   (T_RCD),
      .T_RP    (T_RP),
      .T_BURST (T_BURST)
    ) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .act_i   (act[b]),
      .rd_i    (rd[b]),
      .wr_i    (wr[b]),
      .ap_i    (ap),
      .pre_i   (pre[b]),
      .state_o (st)
    );
    assign bst[b]                = st;
    assign bank_state_o[b*3 +: 3] = st;
  end

  assign cmd_o       = cmd_q;
  assign dev_state_o = dev;

endmodule

// File: tb/ddr2_cmd_tracker_tb.sv
module ddr2_cmd_tracker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NB         = 4;
  localparam int P_INIT     = 8;
  localparam int P_RCD      = 3;
  localparam int P_RP       = 3;
  localparam int P_RFC      = 10;
  localparam int P_BURST    = 2;

  localparam bit [2:0] C_MRS = 3'd0, C_REF = 3'd1, C_PRE = 3'd2, C_ACT = 3'd3,
                       C_WR  = 3'd4, C_RD  = 3'd5, C_RSV = 3'd6, C_NOP = 3'd7;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            cke_i = 1'b1, cs_ni = 1'b1, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1;
  logic [1:0]      ba_i = '0;
  logic            a10_i = 1'b0;
  logic [2:0]      cmd_o;
  logic            illegal_o;
  logic [2:0]      dev_state_o;
  logic [NB*3-1:0] bank_state_o;
  logic            mode_load_o;
  logic [1:0]      mode_sel_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model
  int m_dev, m_dcnt, m_ill, m_ml, m_msel, m_cmd;
  int m_bst [NB];
  int m_bcnt[NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr2_cmd_tracker #(
    .NUM_BANKS (NB), .T_INIT (P_INIT), .T_RCD (P_RCD), .T_RP (P_RP),
    .T_RFC (P_RFC), .T_BURST (P_BURST)
  ) u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .cke_i (cke_i), .cs_ni (cs_ni),
    .ras_ni (ras_ni), .cas_ni (cas_ni), .we_ni (we_ni), .ba_i (ba_i),
    .a10_i (a10_i), .cmd_o (cmd_o), .illegal_o (illegal_o),
    .dev_state_o (dev_state_o), .bank_state_o (bank_state_o),
    .mode_load_o (mode_load_o), .mode_sel_o (mode_sel_o)
  );

  function automatic int bst(int b);
    return int'(bank_state_o[b*3 +: 3]);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_dev = 0; m_dcnt = P_INIT - 1; m_ill = 0; m_ml = 0; m_msel = 0; m_cmd = 7;
    for (int b = 0; b < NB; b++) begin m_bst[b] = 0; m_bcnt[b] = 0; end
  endtask

  task automatic model_step(bit cke, bit cs, bit [2:0] code, int ba, bit a10);
    int cmd, dev_n, cnt_n, ill, ml, tgt;
    bit all_idle, none_tr, any_act, pall_ok;
    bit act[NB], rw[NB], rd[NB], pre[NB];
    cmd = cs ? 7 : int'(code);
    dev_n = m_dev; cnt_n = m_dcnt; ill = 0; ml = 0;
    all_idle = 1; none_tr = 1; any_act = 0; pall_ok = 1;
    for (int b = 0; b < NB; b++) begin
      act[b] = 0; rw[b] = 0; rd[b] = 0; pre[b] = 0;
      if (m_bst[b] != 0) all_idle = 0;
      if (m_bst[b] == 2) any_act = 1;
      if (m_bst[b] != 0 && m_bst[b] != 2) none_tr = 0;
      if (m_bst[b] != 0 && m_bst[b] != 2 && m_bst[b] != 6) pall_ok = 0;
    end
    tgt = m_bst[ba];
    case (m_dev)
      0, 2: begin
        ill = (cmd != 7);
        if (m_dcnt == 0) dev_n = 1; else cnt_n = m_dcnt - 1;
      end
      3, 4, 5: if (cke) dev_n = 1;
      1: begin
        if (!cke) begin
          if (cmd == 1) begin if (all_idle) dev_n = 3; else ill = 1; end
          else if (cmd != 7) ill = 1;
          else if (all_idle) dev_n = 4;
          else if (none_tr && any_act) dev_n = 5;
          else ill = 1;
        end else begin
          case (cmd)
            0: if (all_idle) ml = 1; else ill = 1;
            1: if (all_idle) begin dev_n = 2; cnt_n = P_RFC - 1; end else ill = 1;
            2: begin
              if (a10) begin
                if (pall_ok) for (int b = 0; b < NB; b++) pre[b] = (m_bst[b] == 2);
                else ill = 1;
              end else if (tgt == 2) pre[ba] = 1;
              else if (tgt != 0 && tgt != 6) ill = 1;
            end
            3: if (tgt == 0) act[ba] = 1; else ill = 1;
            4, 5: if (tgt == 2 || tgt == 3 || tgt == 4) begin
                    rw[ba] = 1; rd[ba] = (cmd == 5);
                  end else ill = 1;
            6: ill = 1;
            default: ;
          endcase
        end
      end
      default: ;
    endcase
    for (int b = 0; b < NB; b++) begin
      if (act[b]) begin m_bst[b] = 1; m_bcnt[b] = P_RCD - 1; end
      else if (rw[b]) begin m_bst[b] = a10 ? 5 : (rd[b] ? 3 : 4); m_bcnt[b] = P_BURST - 1; end
      else if (pre[b]) begin m_bst[b] = 6; m_bcnt[b] = P_RP - 1; end
      else begin
        case (m_bst[b])
          1, 3, 4: if (m_bcnt[b] == 0) m_bst[b] = 2; else m_bcnt[b]--;
          5: if (m_bcnt[b] == 0) begin m_bst[b] = 6; m_bcnt[b] = P_RP - 1; end
             else m_bcnt[b]--;
          6: if (m_bcnt[b] == 0) m_bst[b] = 0; else m_bcnt[b]--;
          default: ;
        endcase
      end
    end
    m_ill = ill; m_ml = ml; if (ml) m_msel = ba;
    m_cmd = cmd; m_dev = dev_n; m_dcnt = cnt_n;
  endtask

  task automatic compare_all();
    check("R1 cmd_o", int'(cmd_o), m_cmd);
    check("R10 illegal_o", int'(illegal_o), m_ill);
    check("R9 dev_state_o", int'(dev_state_o), m_dev);
    check("R8 mode_load_o", int'(mode_load_o), m_ml);
    check("R8 mode_sel_o", int'(mode_sel_o), m_msel);
    for (int b = 0; b < NB; b++) check("R5 bank_state_o", bst(b), m_bst[b]);
  endtask

  task automatic drive(bit cke, bit cs, bit [2:0] code, int ba, bit a10);
    cke_i = cke; cs_ni = cs; {ras_ni, cas_ni, we_ni} = code;
    ba_i = ba[1:0]; a10_i = a10;
    @(posedge clk);
    model_step(cke, cs, code, ba, a10);
    @(negedge clk);
    compare_all();
  endtask

  task automatic cmd(bit [2:0] code, int ba, bit a10);
    drive(1'b1, 1'b0, code, ba, a10);
  endtask

  task automatic nops(int n);
    for (int i = 0; i < n; i++) drive(1'b1, 1'b1, C_NOP, 0, 1'b0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    @(negedge clk); @(negedge clk);
    // R2 reset state
    check("R2 reset dev", int'(dev_state_o), 0);
    for (int b = 0; b < NB; b++) check("R2 reset bank", bst(b), 0);
    check("R2 reset illegal", int'(illegal_o), 0);
    check("R2 reset mode_load", int'(mode_load_o), 0);
    rst_ni = 1'b1;

    // R3 activate during init is illegal
    cmd(C_ACT, 0, 0);
    check("R3 init illegal", int'(illegal_o), 1);
    check("R3 init bank unchanged", bst(0), 0);
    nops(1);
    check("R10 pulse one cycle", int'(illegal_o), 0);
    nops(6);
    check("R2 init done", int'(dev_state_o), 1);

    // R4 activate timing
    cmd(C_ACT, 2, 0);
    check("R4 activating", bst(2), 1);
    nops(2);
    check("R4 still activating", bst(2), 1);
    nops(1);
    check("R4 active", bst(2), 2);
    cmd(C_ACT, 2, 0);
    check("R4 act on open bank", int'(illegal_o), 1);

    // R5 column commands
    cmd(C_RD, 1, 0);
    check("R5 read idle bank illegal", int'(illegal_o), 1);
    check("R5 idle bank unchanged", bst(1), 0);
    cmd(C_RD, 2, 0);
    check("R5 reading", bst(2), 3);
    nops(1);
    check("R5 reading hold", bst(2), 3);
    nops(1);
    check("R5 back to active", bst(2), 2);
    cmd(C_WR, 2, 0);
    check("R5 writing", bst(2), 4);

    // R8 mode load with open row
    cmd(C_MRS, 1, 0);
    check("R8 mode load open row illegal", int'(illegal_o), 1);
    check("R8 no mode load", int'(mode_load_o), 0);
    nops(2);

    // R9 active power-down
    drive(1'b0, 1'b1, C_NOP, 0, 0);
    check("R9 active power-down", int'(dev_state_o), 5);
    drive(1'b0, 1'b0, C_RD, 2, 0);
    check("R9 ignored in power-down", int'(illegal_o), 0);
    check("R9 bank kept in power-down", bst(2), 2);
    nops(1);
    check("R9 exit power-down", int'(dev_state_o), 1);

    // R6 auto-precharge
    cmd(C_RD, 2, 1);
    check("R6 auto-precharge", bst(2), 5);
    nops(2);
    check("R6 precharging", bst(2), 6);
    nops(2);
    check("R6 still precharging", bst(2), 6);
    nops(1);
    check("R6 idle", bst(2), 0);

    // R7 single and all-bank precharge
    cmd(C_ACT, 0, 0);
    cmd(C_ACT, 3, 0);
    nops(3);
    cmd(C_PRE, 0, 0);
    check("R7 single precharge", bst(0), 6);
    check("R7 other bank kept", bst(3), 2);
    cmd(C_PRE, 1, 1);
    check("R7 all-bank precharge legal", int'(illegal_o), 0);
    check("R7 all-bank precharge", bst(3), 6);
    nops(3);
    for (int b = 0; b < NB; b++) check("R7 all idle", bst(b), 0);
    cmd(C_ACT, 1, 0);
    nops(1);
    cmd(C_PRE, 0, 1);
    check("R7 all-bank on activating illegal", int'(illegal_o), 1);
    check("R7 activating kept", bst(1), 1);
    nops(2);
    cmd(C_PRE, 1, 0);
    nops(3);
    check("R7 bank1 idle", bst(1), 0);

    // R10 reserved code
    cmd(C_RSV, 0, 0);
    check("R10 reserved illegal", int'(illegal_o), 1);

    // R8 mode load
    cmd(C_MRS, 2, 0);
    check("R8 mode load pulse", int'(mode_load_o), 1);
    check("R8 mode select", int'(mode_sel_o), 2);
    nops(1);
    check("R8 mode load ends", int'(mode_load_o), 0);

    // R8 / R11 refresh
    cmd(C_REF, 0, 0);
    check("R8 refreshing", int'(dev_state_o), 2);
    cmd(C_ACT, 0, 0);
    check("R11 act during refresh", int'(illegal_o), 1);
    check("R11 bank unchanged", bst(0), 0);
    nops(8);
    check("R8 refresh held", int'(dev_state_o), 2);
    nops(1);
    check("R8 refresh done", int'(dev_state_o), 1);

    // R9 self refresh and precharge power-down
    drive(1'b0, 1'b0, C_REF, 0, 0);
    check("R9 self refresh", int'(dev_state_o), 3);
    nops(1);
    check("R9 self refresh exit", int'(dev_state_o), 1);
    drive(1'b0, 1'b1, C_NOP, 0, 0);
    check("R9 precharge power-down", int'(dev_state_o), 4);
    nops(1);

    // R1 decode and chip select masking
    drive(1'b1, 1'b1, C_ACT, 1, 0);
    check("R1 deselect as nop", int'(cmd_o), 7);
    check("R1 deselect no act", bst(1), 0);
    cmd(C_RD, 1, 0);
    check("R1 read code", int'(cmd_o), 5);

    // random phase
    for (int i = 0; i < 5000; i++) begin
      bit       cke, cs, a10;
      bit [2:0] code;
      int       r;
      cke = (($urandom % 12) != 0);
      cs  = (($urandom % 6) == 0);
      r   = $urandom % 16;
      code = (r < 8) ? C_NOP : 3'(r - 8);
      a10 = (($urandom % 3) == 0);
      drive(cke, cs, code, int'($urandom % NB), a10);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule